// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block produces the chip-select (CS), address-strobe (AS), data-strobe (DS) and write-enable (WE) waveforms for external static RAM. The RAM shares its bus with a display refresh engine. Every access opens with a display fetch slot and then runs one or two byte/word transfers. The sequencer is clocked by a tick at twice the CPU clock rate, so every edge falls on a half-clock boundary. In the text below, one tick is one half CPU clock. All strobes are active high at the ports.

A 16-bit control word holds six trims:
- WE can end early, with an optional extra clock of margin before CS negates.
- The display slot can be lengthened by one clock.
- AS, DS and CS each have a toggle bit. It decides whether that strobe drops or stays asserted between the two byte halves of a 16-bit access to an 8-bit port.

The trims and the request fields are captured when a request is accepted. A write to the register during an access therefore takes effect on the next access. Address decoding and the display engine itself are outside this block.

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset the control register reads 0x9C00.
- R2: The control bits sit at fixed positions: bit 15 early WE end, bit 14 margin extension, bit 13 display-slot trim, bit 12 AS toggle, bit 11 DS toggle, bit 10 CS toggle. They read back as written. Bits 9..0 always read zero.
- R3: WE asserts one tick after CS in each write transfer. With bit 15 clear, WE negates together with CS. With bit 15 set, WE negates one tick before CS. With bits 15 and 14 both set, WE negates three ticks before CS.
- R4: With bit 15 clear, bit 14 has no effect on any output.
- R5: With zero wait states and bit 13 clear, a single transfer takes 8 ticks from the start of the display slot to CS negation. The display slot lasts 4 ticks. CS, AS and DS last 5 ticks, and CS asserts in the last tick of the display slot.
- R6: With bit 13 set, the display slot lasts 6 ticks, and the transfer starts 2 ticks later.
- R7: Each programmed wait state lengthens CS, AS and DS of every transfer by 2 ticks.
- R8: A 16-bit request on an 8-bit port runs two transfers, the even address first and then the odd address. Any other request runs one transfer at the unchanged address.
- R9: Between the two transfers of a split access there is one gap tick. During that tick each of AS, DS and CS is deasserted if its toggle bit is set and held asserted if it is clear. WE is deasserted during the gap.
- R10: done_o is high for exactly one tick: the first tick after the last transfer, with all strobes low. A request is accepted only while idle; requests seen during an access or during the done tick are ignored.
- R11: A read access never asserts WE. Its CS, AS and DS timing is the same as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the CPU clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 16 | Control register write data |
| reg_rdata_o | output | 16 | Control register read data |
| req_i | input | 1 | Access request, sampled while idle |
| req_addr_i | input | ADDR_W | Access address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit access |
| req_wait_i | input | WAIT_W | Programmed wait states |
| port8_i | input | 1 | Target port is 8 bits wide |
| mem_addr_o | output | ADDR_W | Address of the current transfer |
| cs_o | output | 1 | Chip select |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| we_o | output | 1 | Write enable |
| lcd_slot_o | output | 1 | Display fetch slot active |
| done_o | output | 1 | Access complete pulse |

## Verification
The bench programs each trim combination and compares every strobe in every tick of the access against a timeline built from the requirements.

It covers these corner cases:
- The overlap tick where CS meets the display slot. A design without the overlap would stretch the access to 9 ticks.
- WE negation with each early/margin setting. A wrong design would cut WE too soon or leave no gap before CS negation.
- The margin bit with early end clear, which must change nothing.
- Each single toggle bit on a split access. A crossed bit would drop the wrong strobe in the gap tick.
- The byte order of a split access. A wrong design would present the odd address first.
- Requests injected mid-access and during the done tick. A design that accepted them would restart, change address or shorten the access.

// File: rtl/sss_pkg.sv
package sss_pkg;

  // field order matches register bits 15..10
  typedef struct packed {
    logic we_early;
    logic we_ext;
    logic lcd_trim;
    logic as_tog;
    logic ds_tog;
    logic cs_tog;
  } ctrl_t;

  localparam logic [15:0] CTRL_RST = 16'h9C00;
  localparam int unsigned CTRL_LSB = 10;
  localparam int unsigned NSTRB    = 3;  // 0 AS, 1 DS, 2 CS

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LCD  = 3'd1,
    ST_XFER = 3'd2,
    ST_GAP  = 3'd3,
    ST_DONE = 3'd4
  } st_e;

endpackage

// File: rtl/sss_ctrl_reg.sv
module sss_ctrl_reg
  import sss_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [15:10]  wdata_i,
  output ctrl_t         cfg_o,
  output logic [15:0]   rdata_o
);

  ctrl_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= ctrl_t'(CTRL_RST[15:CTRL_LSB]);
    else if (wr_i) cfg_q <= ctrl_t'(wdata_i);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q, {CTRL_LSB{1'b0}}};

endmodule

// File: rtl/sss_timing.sv
module sss_timing #(
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              lcd_trim_i,
  input  logic              we_early_i,
  input  logic              we_ext_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic [CNT_W-1:0]  lcd_last_o,
  output logic [CNT_W-1:0]  xfer_last_o,
  output logic [CNT_W-1:0]  we_last_o
);

  localparam logic [CNT_W-1:0] LCD_BASE  = CNT_W'(2);  // 4-tick slot, last tick overlaps CS
  localparam logic [CNT_W-1:0] LCD_TRIM  = CNT_W'(4);
  localparam logic [CNT_W-1:0] XFER_BASE = CNT_W'(4);  // 5-tick CS

  logic [CNT_W-1:0] xfer_last;

  assign lcd_last_o  = lcd_trim_i ? LCD_TRIM : LCD_BASE;
  assign xfer_last   = XFER_BASE + (CNT_W'(wait_i) << 1);
  assign xfer_last_o = xfer_last;

  always_comb begin
    if (!we_early_i)   we_last_o = xfer_last;
    else if (we_ext_i) we_last_o = xfer_last - CNT_W'(3);
    else               we_last_o = xfer_last - CNT_W'(1);
  end

endmodule

// File: rtl/sss_fsm.sv
module sss_fsm
  import sss_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_wide_i,
  input  logic [WAIT_W-1:0] req_wait_i,
  input  logic              port8_i,
  input  ctrl_t             cfg_i,
  input  logic [CNT_W-1:0]  lcd_last_i,
  input  logic [CNT_W-1:0]  xfer_last_i,
  output st_e               st_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              second_o,
  output ctrl_t             cfg_o,
  output logic              write_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [ADDR_W-1:0] addr_o
);

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              second_q;
  ctrl_t             cfg_q;
  logic              write_q;
  logic              split_q;
  logic [WAIT_W-1:0] wait_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      second_q <= 1'b0;
      cfg_q    <= ctrl_t'(CTRL_RST[15:CTRL_LSB]);
      write_q  <= 1'b0;
      split_q  <= 1'b0;
      wait_q   <= '0;
      addr_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            cfg_q    <= cfg_i;
            write_q  <= req_write_i;
            split_q  <= req_wide_i & port8_i;
            wait_q   <= req_wait_i;
            addr_q   <= req_addr_i;
            cnt_q    <= '0;
            second_q <= 1'b0;
            st_q     <= ST_LCD;
          end
        end
        ST_LCD: begin
          if (cnt_q == lcd_last_i) begin
            cnt_q <= '0;
            st_q  <= ST_XFER;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_XFER: begin
          if (cnt_q == xfer_last_i) begin
            cnt_q <= '0;
            st_q  <= (split_q && !second_q) ? ST_GAP : ST_DONE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_GAP: begin
          second_q <= 1'b1;
          st_q     <= ST_XFER;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o     = st_q;
  assign cnt_o    = cnt_q;
  assign second_o = second_q;
  assign cfg_o    = cfg_q;
  assign write_o  = write_q;
  assign wait_o   = wait_q;
  // split access: even byte first, odd byte second
  assign addr_o   = split_q ? {addr_q[ADDR_W-1:1], second_q} : addr_q;

endmodule

// File: rtl/sss_strobe_dec.sv
module sss_strobe_dec
  import sss_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  st_e              st_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             second_i,
  input  logic             write_i,
  input  logic [NSTRB-1:0] tog_i,
  input  logic [CNT_W-1:0] we_last_i,
  output logic [NSTRB-1:0] strb_o,
  output logic             we_o,
  output logic             lcd_slot_o,
  output logic             done_o
);

  logic in_xfer, in_gap;

  assign in_xfer = (st_i == ST_XFER);
  assign in_gap  = (st_i == ST_GAP);

  for (genvar i = 0; i < NSTRB; i++) begin : g_strb
    assign strb_o[i] = in_xfer | (in_gap & ~tog_i[i]);
  end

  assign we_o       = in_xfer & write_i & (cnt_i != '0) & (cnt_i <= we_last_i);
  assign lcd_slot_o = (st_i == ST_LCD) | (in_xfer & ~second_i & (cnt_i == '0));
  assign done_o     = (st_i == ST_DONE);

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sss_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_wide_i,
  input  logic [WAIT_W-1:0] req_wait_i,
  input  logic              port8_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              cs_o,
  output logic              as_o,
  output logic              ds_o,
  output logic              we_o,
  output logic              lcd_slot_o,
  output logic              done_o
);

  localparam int unsigned CNT_W = $clog2(6 + 2 * (1 << WAIT_W));

  ctrl_t             cfg_live, cfg_acc;
  st_e               st;
  logic [CNT_W-1:0]  cnt, lcd_last, xfer_last, we_last;
  logic              second, write_acc;
  logic [WAIT_W-1:0] wait_acc;
  logic [NSTRB-1:0]  strb;
  logic              unused_rsvd;

  assign unused_rsvd = ^reg_wdata_i[CTRL_LSB-1:0];

  sss_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_we_i),
    .wdata_i (reg_wdata_i[15:CTRL_LSB]),
    .cfg_o   (cfg_live),
    .rdata_o (reg_rdata_o)
  );

  sss_fsm #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .req_wide_i  (req_wide_i),
    .req_wait_i  (req_wait_i),
    .port8_i     (port8_i),
    .cfg_i       (cfg_live),
    .lcd_last_i  (lcd_last),
    .xfer_last_i (xfer_last),
    .st_o        (st),
    .cnt_o       (cnt),
    .second_o    (second),
    .cfg_o       (cfg_acc),
    .write_o     (write_acc),
    .wait_o      (wait_acc),
    .addr_o      (mem_addr_o)
  );

  sss_timing #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_tim (
    .lcd_trim_i  (cfg_acc.lcd_trim),
    .we_early_i  (cfg_acc.we_early),
    .we_ext_i    (cfg_acc.we_ext),
    .wait_i      (wait_acc),
    .lcd_last_o  (lcd_last),
    .xfer_last_o (xfer_last),
    .we_last_o   (we_last)
  );

  sss_strobe_dec #(.CNT_W(CNT_W)) u_dec (
    .st_i       (st),
    .cnt_i      (cnt),
    .second_i   (second),
    .write_i    (write_acc),
    .tog_i      ({cfg_acc.cs_tog, cfg_acc.ds_tog, cfg_acc.as_tog}),
    .we_last_i  (we_last),
    .strb_o     (strb),
    .we_o       (we_o),
    .lcd_slot_o (lcd_slot_o),
    .done_o     (done_o)
  );

  assign as_o = strb[0];
  assign ds_o = strb[1];
  assign cs_o = strb[2];

endmodule

// File: rtl/sram_strobe_seq_chk.sv
module sram_strobe_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] reg_rdata_o,
  input logic        cs_o,
  input logic        as_o,
  input logic        ds_o,
  input logic        we_o,
  input logic        lcd_slot_o,
  input logic        done_o
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[9:0] == 10'd0);

  // R3
  we_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> cs_o && ds_o);

  // R5
  lcd_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_slot_o && cs_o) |=> !lcd_slot_o && cs_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o && !as_o && !ds_o && !we_o && !lcd_slot_o);

endmodule

bind sram_strobe_seq sram_strobe_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rdata_o (reg_rdata_o),
  .cs_o        (cs_o),
  .as_o        (as_o),
  .ds_o        (ds_o),
  .we_o        (we_o),
  .lcd_slot_o  (lcd_slot_o),
  .done_o      (done_o)
);

// File: tb/sram_strobe_seq_tb_top.sv
module sram_strobe_seq_tb_top;

  localparam int AW = 24;
  localparam int WW = 3;
  localparam int NV = 11;
  // {cfg[15:0], write, wide, port8, wait[2:0], addr[23:0]}
  localparam logic [45:0] VEC [NV] = '{
    {16'h9C00, 1'b1, 1'b1, 1'b0, 3'd0, 24'h000100}, // R5 R3 default, single write
    {16'h9C00, 1'b1, 1'b1, 1'b1, 3'd0, 24'h000101}, // R8 R9 split, all toggles
    {16'h0000, 1'b1, 1'b0, 1'b0, 3'd0, 24'h000202}, // R3 WE ends with CS
    {16'h4000, 1'b1, 1'b0, 1'b0, 3'd0, 24'h000202}, // R4 margin ignored
    {16'hC000, 1'b1, 1'b0, 1'b0, 3'd1, 24'h000303}, // R3 R7 early+margin, 1 wait
    {16'h2000, 1'b0, 1'b1, 1'b0, 3'd2, 24'h000404}, // R6 R11 trim, read, 2 waits
    {16'h1000, 1'b1, 1'b1, 1'b1, 3'd0, 24'h000505}, // R9 AS toggle only
    {16'h0800, 1'b0, 1'b1, 1'b1, 3'd1, 24'h000606}, // R9 R11 DS toggle only
    {16'h8400, 1'b1, 1'b1, 1'b1, 3'd0, 24'h000707}, // R9 CS toggle only
    {16'h0000, 1'b1, 1'b1, 1'b1, 3'd7, 24'h000808}, // R7 R9 no toggles, max wait
    {16'hE000, 1'b1, 1'b0, 1'b1, 3'd3, 24'hABCDEF}  // R8 byte on 8-bit port, single
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [15:0]   reg_wdata_i = '0;
  logic [15:0]   reg_rdata_o;
  logic          req_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_write_i = 1'b0;
  logic          req_wide_i = 1'b0;
  logic [WW-1:0] req_wait_i = '0;
  logic          port8_i = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic          cs_o, as_o, ds_o, we_o, lcd_slot_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  sram_strobe_seq #(.ADDR_W(AW), .WAIT_W(WW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_write_i(req_write_i), .req_wide_i(req_wide_i), .req_wait_i(req_wait_i),
    .port8_i(port8_i), .mem_addr_o(mem_addr_o), .cs_o(cs_o), .as_o(as_o),
    .ds_o(ds_o), .we_o(we_o), .lcd_slot_o(lcd_slot_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // run one access; c counts ticks from the first display-slot tick
  task automatic run_access(input logic [45:0] v, input bit inject);
    logic [15:0] cfg;
    logic wr, split;
    logic [AW-1:0] ad;
    int w, L, T, x1, done_c, we_end, t, sec;
    logic e_lcd, e_cs, e_as, e_ds, e_we, e_done, in_x, in_g;
    cfg = v[45:30]; wr = v[29]; split = v[28] & v[27]; w = int'(v[26:24]); ad = v[23:0];
    write_reg(cfg);
    chk("R2 readback", {16'h0, reg_rdata_o}, {16'h0, cfg[15:10], 10'h0});
    L = cfg[13] ? 6 : 4;
    T = 5 + 2 * w;
    x1 = L - 1;
    done_c = split ? x1 + 2 * T + 1 : x1 + T;
    we_end = !cfg[15] ? T - 1 : (cfg[14] ? T - 4 : T - 2);
    req_write_i = wr; req_wide_i = v[28]; port8_i = v[27]; req_wait_i = v[26:24];
    req_addr_i = ad; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int c = 0; c <= done_c + 2; c++) begin
      in_x = 1'b0; in_g = 1'b0; t = 0; sec = 0;
      if (c >= x1 && c < x1 + T) begin in_x = 1'b1; t = c - x1; end
      else if (split && c == x1 + T) in_g = 1'b1;
      else if (split && c > x1 + T && c <= x1 + 2 * T) begin in_x = 1'b1; t = c - x1 - T - 1; sec = 1; end
      e_lcd  = (c < L);
      e_cs   = in_x | (in_g & ~cfg[10]);
      e_ds   = in_x | (in_g & ~cfg[11]);
      e_as   = in_x | (in_g & ~cfg[12]);
      e_we   = in_x & wr & (t >= 1) & (t <= we_end);
      e_done = (c == done_c);
      chk("R6 lcd_slot", {31'h0, lcd_slot_o}, {31'h0, e_lcd});
      chk("R5 cs",       {31'h0, cs_o},       {31'h0, e_cs});
      chk("R9 as",       {31'h0, as_o},       {31'h0, e_as});
      chk("R9 ds",       {31'h0, ds_o},       {31'h0, e_ds});
      chk("R3 we",       {31'h0, we_o},       {31'h0, e_we});
      chk("R10 done",    {31'h0, done_o},     {31'h0, e_done});
      if (in_x)
        chk("R8 addr", {8'h0, mem_addr_o},
            {8'h0, split ? {ad[AW-1:1], sec[0]} : ad});
      if (inject && (c == 2 || c == done_c)) begin
        req_i = 1'b1; req_addr_i = ~ad; req_write_i = ~wr; req_wait_i = '1;
      end else begin
        req_i = 1'b0;
      end
      @(negedge clk_i);
    end
    req_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 reset reg", {16'h0, reg_rdata_o}, 32'h9C00);
    chk("R10 reset idle", {26'h0, cs_o, as_o, ds_o, we_o, lcd_slot_o, done_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {16'h0, reg_rdata_o}, 32'h9C00);
    // R2 reserved bits
    write_reg(16'hFFFF);
    chk("R2 rsvd ones", {16'h0, reg_rdata_o}, 32'hFC00);
    write_reg(16'h03FF);
    chk("R2 rsvd only", {16'h0, reg_rdata_o}, 32'h0000);

    for (int i = 0; i < NV; i++) run_access(VEC[i], 1'b0);

    // R10 requests during access and during done tick are ignored
    run_access(VEC[1], 1'b1);
    run_access(VEC[4], 1'b1);
    // R11 read with early end set: no WE
    run_access({16'hDC00, 1'b0, 1'b1, 1'b1, 3'd2, 24'h000A0A}, 1'b0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule